// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Programmable Bit Rate

This block turns bytes into an asynchronous serial stream on one output line. A byte arrives on a valid/ready input and first waits in a holding register. It moves into an internal shift register as soon as that register is free, so the host can hand over the next byte while the current frame is still leaving the line. A frame is a low start bit, the data with the least significant bit first, an optional ninth bit, and a high stop bit. The ninth bit can carry an address marker, a software parity bit, or a second stop bit.

The bit rate comes from an 8-bit divisor and a speed select. In fast mode a bit lasts (divisor+1)×16 clocks. In slow mode it lasts (divisor+1)×64 clocks. For example, a 4 MHz clock in fast mode with divisor 25 gives 9615 bit/s. Two flags report the state of the two registers separately. Clearing the enable stops all activity at once.

Input handshake rules: a byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the holding register is empty and the transmitter is enabled. The host must keep `in_valid` and `in_data` steady until the byte is taken. The ninth-bit value is not sampled on the handshake. It is sampled in the cycle the holding register hands its byte to the shift register.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `shift_empty` is 1. `txd` stays 1 whenever no frame is being sent.
- R2: Each frame drives `txd` as follows: one bit of 0, then the data bits with bit 0 first, then one stop bit of 1.
- R3: When `nine_mode` is 1, the value of `ninth_bit` goes out as an extra bit after data bit 7 and before the stop bit. When `nine_mode` is 0, the frame has exactly 10 bit periods.
- R4: A byte written while a frame is shifting waits in the holding register. It is not lost or altered. Its start bit follows the previous stop bit with no idle cycle in between.
- R5: `in_ready` equals `hold_empty` AND `tx_en`.
  - On the clock after a handshake, `hold_empty` reads 0.
  - If the shift register is idle, `hold_empty` returns to 1 one clock later. On that same clock, `shift_empty` falls and `txd` goes low.
- R6: `ninth_bit` is sampled on the clock where the holding register transfers into the shift register, not on the handshake clock.
- R7: Each bit lasts (`divisor`+1)×16 clocks when `fast_mode` is 1, and (`divisor`+1)×64 clocks when it is 0.
- R8: `shift_empty` is 0 from the start bit through the end of the stop bit, and 1 otherwise.
- R9: While `tx_en` is 0:
  - Input is refused: `in_ready` is 0.
  - Clearing `tx_en` mid-frame ends the frame on the next clock. `txd` returns to 1, both empty flags read 1, and any byte in the holding register is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; 0 aborts and flushes |
| nine_mode | input | 1 | 1 selects frames with a ninth bit |
| ninth_bit | input | 1 | Ninth bit value, sampled at transfer into the shift register |
| fast_mode | input | 1 | 1 selects ×16 prescale, 0 selects ×64 |
| divisor | input | 8 | Bit-rate divisor, 0 to 255 |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken |
| in_data | input | 8 | Byte to send |
| hold_empty | output | 1 | Holding register is empty |
| shift_empty | output | 1 | No frame is being shifted out |
| txd | output | 1 | Serial output line |

## Verification
The bench decodes frames for several combinations of divisor, speed and frame length. It also measures the exact width of a start bit. A prescale or divisor off by one would show up as a wrong start-bit width and as corrupted bits at mid-bit sampling. It sends two bytes back to back and limits the idle time between the frames, which catches a transmitter that idles a cycle or drops the queued byte. Other directed tests cover the following:
- The flag sequence around a write to an idle transmitter.
- A change of `ninth_bit` after the handshake, which exposes capture at the wrong moment.
- An abort with a byte queued, which must leave the line high and both flags set.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam logic LINE_MARK  = 1'b1;
  localparam logic LINE_SPACE = 1'b0;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_RUN  = 1'b1
  } sh_state_t;
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W    = 8,
  parameter int PRE_FAST = 16,
  parameter int PRE_SLOW = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fast,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  localparam int PRE_W = $clog2(PRE_SLOW);

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_lim;
  logic             pre_wrap;

  assign pre_lim  = fast ? PRE_W'(PRE_FAST - 1) : PRE_W'(PRE_SLOW - 1);
  assign pre_wrap = (pre_q == pre_lim);
  assign tick     = run && pre_wrap && (div_q == divisor);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (!run) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (pre_wrap) begin
      pre_q <= '0;
      div_q <= (div_q == divisor) ? '0 : div_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R7
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign in_ready = !full_q && tx_en;
  assign full     = full_q;
  assign data     = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (!tx_en) begin
      full_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take && tx_en) |=> (full_q && $stable(data_q))); // R4
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> full_q); // R5
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              nine,
  input  logic              bit9,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              busy,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W);

  sh_state_t          st_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               last;
  logic [FRAME_W-1:0] frame_in;

  assign busy     = (st_q == SH_RUN);
  assign last     = busy && tick && (cnt_q == '0);
  assign take     = tx_en && hold_full && (!busy || last);
  assign frame_in = {LINE_MARK, (nine ? bit9 : LINE_MARK), hold_data, LINE_SPACE};
  assign txd      = busy ? sh_q[0] : LINE_MARK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SH_IDLE;
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (!tx_en) begin
      st_q  <= SH_IDLE;
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (take) begin
      st_q  <= SH_RUN;
      sh_q  <= frame_in;
      cnt_q <= nine ? CNT_W'(FRAME_W - 1) : CNT_W'(FRAME_W - 2);
    end else if (last) begin
      st_q <= SH_IDLE;
    end else if (busy && tick) begin
      sh_q  <= {LINE_MARK, sh_q[FRAME_W-1:1]};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd); // R2
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick && cnt_q == '0) |-> txd); // R2
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!busy && txd)); // R9
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 8,
  parameter int PRE_FAST = 16,
  parameter int PRE_SLOW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              nine_mode,
  input  logic              ninth_bit,
  input  logic              fast_mode,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              txd
);
  logic              tick;
  logic              take;
  logic              busy;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;

  uart_baud_gen #(
    .DIV_W   (DIV_W),
    .PRE_FAST(PRE_FAST),
    .PRE_SLOW(PRE_SLOW)
  ) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .fast   (fast_mode),
    .divisor(divisor),
    .tick   (tick)
  );

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .in_valid(in_valid),
    .in_data (in_data),
    .in_ready(in_ready),
    .take    (take),
    .full    (hold_full),
    .data    (hold_data)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .nine     (nine_mode),
    .bit9     (ninth_bit),
    .tick     (tick),
    .hold_full(hold_full),
    .hold_data(hold_data),
    .take     (take),
    .busy     (busy),
    .txd      (txd)
  );

  assign hold_empty  = !hold_full;
  assign shift_empty = !busy;

  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> txd); // R1
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (hold_empty && tx_en)); // R5
endmodule

// File: tb/test_uart_tx_core.sv
module test_uart_tx_core;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       nine_mode = 1'b0;
  logic       ninth_bit = 1'b0;
  logic       fast_mode = 1'b1;
  logic [7:0] divisor = 8'd0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic       in_ready, hold_empty, shift_empty, txd;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  uart_tx_core i_uart_tx_core (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .nine_mode(nine_mode),
    .ninth_bit(ninth_bit), .fast_mode(fast_mode), .divisor(divisor),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .hold_empty(hold_empty), .shift_empty(shift_empty), .txd(txd)
  );

  // vector: [18:11] data, [10] nine, [9] ninth, [8] fast, [7:0] divisor
  localparam logic [18:0] VEC [6] = '{
    {8'hA5, 1'b0, 1'b0, 1'b1, 8'd0},
    {8'h3C, 1'b1, 1'b1, 1'b1, 8'd1},
    {8'h00, 1'b1, 1'b0, 1'b1, 8'd2},
    {8'hFF, 1'b0, 1'b0, 1'b0, 8'd0},
    {8'h81, 1'b1, 1'b1, 1'b0, 8'd1},
    {8'h6E, 1'b0, 1'b0, 1'b1, 8'd3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int period(input logic fast, input logic [7:0] d);
    return (int'(d) + 1) * (fast ? 16 : 64);
  endfunction

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic nine, input logic b9);
    return {1'b1, nine ? b9 : 1'b1, d, 1'b0};
  endfunction

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rx(input int per, input int nb, output logic [10:0] got);
    got = '1;
    while (txd !== 1'b0) @(negedge clk);
    repeat (per/2) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < nb; i++) begin
      repeat (per) @(negedge clk);
      got[i] = txd;
    end
  endtask

  task automatic settle();
    while (!shift_empty) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000 && !done) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [10:0] got, got2;
    int per, gap, n;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1, "R1 txd after reset", txd, 1);
    chk(hold_empty === 1'b1 && shift_empty === 1'b1, "R1 flags after reset",
        {hold_empty, shift_empty}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 disabled: input refused, nothing sent
    in_valid = 1'b1;
    in_data  = 8'h42;
    repeat (4) @(negedge clk);
    chk(in_ready === 1'b0, "R9 ready while disabled", in_ready, 0);
    in_valid = 1'b0;
    tx_en = 1'b1;
    repeat (30) @(negedge clk);
    chk(txd === 1'b1 && shift_empty === 1'b1 && hold_empty === 1'b1,
        "R9 refused byte not sent", {txd, shift_empty, hold_empty}, 7);

    // R2 R3 R7 table walk
    foreach (VEC[k]) begin
      nine_mode = VEC[k][10];
      ninth_bit = VEC[k][9];
      fast_mode = VEC[k][8];
      divisor   = VEC[k][7:0];
      per = period(VEC[k][8], VEC[k][7:0]);
      fork
        rx(per, VEC[k][10] ? 11 : 10, got);
        push(VEC[k][18:11]);
      join
      chk(got === exp_frame(VEC[k][18:11], VEC[k][10], VEC[k][9]),
          VEC[k][10] ? "R3 nine-bit frame" : "R2 eight-bit frame",
          got, exp_frame(VEC[k][18:11], VEC[k][10], VEC[k][9]));
      settle();
    end

    // R7 exact start-bit width, slow and fast
    nine_mode = 1'b0; fast_mode = 1'b0; divisor = 8'd1;
    push(8'h01);
    while (txd !== 1'b0) @(negedge clk);
    n = 0;
    while (txd === 1'b0) begin n++; @(negedge clk); end
    chk(n == 128, "R7 slow bit width", n, 128);
    settle();
    fast_mode = 1'b1; divisor = 8'd2;
    push(8'h01);
    while (txd !== 1'b0) @(negedge clk);
    n = 0;
    while (txd === 1'b0) begin n++; @(negedge clk); end
    chk(n == 48, "R7 fast bit width", n, 48);
    settle();

    // R5 R8 flag timing on write to idle transmitter
    divisor = 8'd0;
    push(8'hC3);
    chk(hold_empty === 1'b0 && shift_empty === 1'b1 && txd === 1'b1,
        "R5 flags after handshake", {hold_empty, shift_empty, txd}, 3'b011);
    chk(in_ready === 1'b0, "R5 ready low when holding full", in_ready, 0);
    @(negedge clk);
    chk(hold_empty === 1'b1 && shift_empty === 1'b0 && txd === 1'b0,
        "R8 transfer starts frame", {hold_empty, shift_empty, txd}, 3'b100);
    settle();

    // R4 back to back without idle gap
    per = 16;
    fork
      begin
        rx(per, 10, got);
        gap = 0;
        while (txd === 1'b1) begin gap++; @(negedge clk); end
        rx(per, 10, got2);
      end
      begin
        push(8'h5A);
        push(8'h96);
      end
    join
    chk(got === exp_frame(8'h5A, 0, 0), "R4 first queued frame", got, exp_frame(8'h5A, 0, 0));
    chk(got2 === exp_frame(8'h96, 0, 0), "R4 second queued frame", got2, exp_frame(8'h96, 0, 0));
    chk(gap <= per/2 + 1, "R4 no idle gap", gap, per/2 + 1);
    settle();

    // R6 ninth bit sampled at transfer, not at handshake
    nine_mode = 1'b1;
    ninth_bit = 1'b0;
    fork
      begin
        rx(per, 11, got);
        rx(per, 11, got2);
      end
      begin
        push(8'h11);
        push(8'h22);
        ninth_bit = 1'b1;
      end
    join
    chk(got === exp_frame(8'h11, 1, 0), "R6 first ninth bit", got, exp_frame(8'h11, 1, 0));
    chk(got2 === exp_frame(8'h22, 1, 1), "R6 ninth bit at transfer", got2, exp_frame(8'h22, 1, 1));
    settle();

    // R9 abort mid-frame with a queued byte
    nine_mode = 1'b0;
    push(8'hF0);
    push(8'h0F);
    repeat (20) @(negedge clk);
    chk(shift_empty === 1'b0 && hold_empty === 1'b0, "R9 busy before abort",
        {shift_empty, hold_empty}, 0);
    tx_en = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1 && shift_empty === 1'b1 && hold_empty === 1'b1,
        "R9 abort idles line", {txd, shift_empty, hold_empty}, 7);
    tx_en = 1'b1;
    repeat (200) @(negedge clk);
    chk(txd === 1'b1 && shift_empty === 1'b1, "R9 flushed byte not sent",
        {txd, shift_empty}, 3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule